// File: doc/BRIEF.md
# Coarse-grained thread switch controller

This block decides which of several hardware threads owns the single issue slot of an in-order pipeline. The owning thread issues one instruction per cycle until the pipeline flags that the instruction just issued has hit a long-latency stall, such as a load that missed in every cache and must go off-chip. That thread is then parked. After one scheduler cycle with no issue, the slot goes to the next ready thread. A parked thread becomes ready again when the memory system signals a data return tagged with its thread number.

Each thread has its own program counter register. A switch does not copy or save anything. It only changes which counter is selected, so a parked thread resumes exactly where it stopped. Per-thread enables limit which threads may be scheduled. Thread 0 can always be scheduled. NTHR must be a power of two.

Top module: `tsw_ctrl`

## Requirements
- R1: After reset, `act_tid` is 0 and `issue_vld` is 1. Thread t's PC holds PC_BASE + t*PC_STEP. A thread starts ready only if its enable bit is set. Thread 0 always starts ready.
- R2: While `issue_vld` is 1 and `stall_evt` is 0, the same thread issues again in the next cycle. Each issuing cycle advances the active thread's PC by PC_INC and leaves every other PC unchanged.
- R3: When `stall_evt` is 1 in an issuing cycle, the following cycle is a scheduler cycle with `issue_vld` 0. If another thread is eligible, it issues in the cycle after that.
- R4: The scheduler picks the first eligible thread in the order act+1, act+2, … (modulo NTHR), with the current thread considered last. A thread is eligible when it is ready and its enable bit is set (thread 0 is always enabled).
- R5: A stalled thread leaves the ready set and is not picked again until a data return (`ret_evt` 1 with `ret_tid` equal to its number) arrives.
- R6: While no thread is eligible, `issue_vld` stays 0 and all PCs stay unchanged. A data return in cycle c makes that thread issue in cycle c+2, from its saved PC.
- R7: A data return for a thread that is already ready has no effect. A running thread keeps issuing.
- R8: A stall and a data return for the same thread in the same cycle leave that thread stalled.
- R9: A thread whose enable bit is 0 is never picked, even if it is ready.
- R10: `stall_evt` is ignored in cycles where `issue_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_en | input | NTHR | Per-thread scheduling enable (bit 0 treated as 1) |
| stall_evt | input | 1 | The instruction issued this cycle has hit a long-latency stall |
| ret_evt | input | 1 | Memory data return |
| ret_tid | input | $clog2(NTHR) | Thread number of the data return |
| act_tid | output | $clog2(NTHR) | Thread that owns the issue slot |
| issue_vld | output | 1 | An instruction of `act_tid` issues this cycle |
| pc_bank | output | NTHR*PCW | All thread PCs, thread t at bits [t*PCW +: PCW] |

## Verification
The bench uses the default build: four threads, 32-bit PCs, a step of 4 and distinct 4 KiB-spaced start addresses. Four threads are enough to reach several kinds of case. A disabled thread can sit between two eligible ones, so the round-robin search must skip it. Every thread can be stalled at once, which exercises the idle wait. Returns can arrive for running, ready, parked and disabled threads. The distinct start addresses make any mix-up between PC copies visible in the bank.

// File: rtl/tsw_ctrl.sv
module tsw_ctrl #(
  parameter int NTHR    = 4,
  parameter int PCW     = 32,
  parameter int PC_INC  = 4,
  parameter int PC_BASE = 32'h0000_1000,
  parameter int PC_STEP = 32'h0000_1000,
  localparam int TW     = $clog2(NTHR)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     thr_en,
  input  logic                stall_evt,
  input  logic                ret_evt,
  input  logic [TW-1:0]       ret_tid,
  output logic [TW-1:0]       act_tid,
  output logic                issue_vld,
  output logic [NTHR*PCW-1:0] pc_bank
);

  logic            run_q;
  logic [TW-1:0]   act_q;
  logic [NTHR-1:0] rdy_q, rdy_n, cand;
  logic [TW-1:0]   pick;
  logic            found;
  logic            take;

  assign take      = run_q & stall_evt;
  assign cand      = rdy_q & (thr_en | NTHR'(1));
  assign act_tid   = act_q;
  assign issue_vld = run_q;

  always_comb begin
    pick  = act_q;
    found = 1'b0;
    for (int k = NTHR; k >= 1; k--) begin
      logic [TW-1:0] idx;
      idx = act_q + TW'(k);
      if (cand[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    rdy_n = rdy_q;
    if (take) rdy_n[act_q] = 1'b0;
    if (ret_evt && !(take && ret_tid == act_q)) rdy_n[ret_tid] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      act_q <= '0;
      rdy_q <= thr_en | NTHR'(1);
    end else begin
      rdy_q <= rdy_n;
      if (take) begin
        run_q <= 1'b0;
      end else if (!run_q && found) begin
        run_q <= 1'b1;
        act_q <= pick;
      end
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_pc
    logic [PCW-1:0] pc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pc_q <= PCW'(PC_BASE) + PCW'(t) * PCW'(PC_STEP);
      else if (run_q && act_q == TW'(t))
        pc_q <= pc_q + PCW'(PC_INC);
    end
    assign pc_bank[t*PCW +: PCW] = pc_q;
  end

endmodule

// File: rtl/tsw_ctrl_chk.sv
module tsw_ctrl_chk #(
  parameter int NTHR   = 4,
  parameter int PCW    = 32,
  parameter int PC_INC = 4,
  localparam int TW    = $clog2(NTHR)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NTHR-1:0]     thr_en,
  input logic                stall_evt,
  input logic [TW-1:0]       act_tid,
  input logic                issue_vld,
  input logic [NTHR*PCW-1:0] pc_bank
);

  logic [NTHR-1:0] en_d;
  logic [TW-1:0]   tid_d;
  logic [PCW-1:0]  pc_d;
  logic            vld_d;
  logic [PCW-1:0]  pc_cur;

  assign pc_cur = pc_bank[act_tid*PCW +: PCW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= '1;
      tid_d <= '0;
      pc_d  <= '0;
      vld_d <= 1'b0;
    end else begin
      en_d  <= thr_en | NTHR'(1);
      tid_d <= act_tid;
      pc_d  <= pc_cur;
      vld_d <= issue_vld;
    end
  end

  AST_STALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && stall_evt |=> !issue_vld); // R3
  AST_HOLD_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && !stall_evt |=> issue_vld && $stable(act_tid)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_d |-> pc_bank[tid_d*PCW +: PCW] == pc_d + PCW'(PC_INC)); // R2
  AST_IDLE_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(pc_bank)); // R6
  AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_vld) |-> en_d[act_tid]); // R9

endmodule

bind tsw_ctrl tsw_ctrl_chk #(.NTHR(NTHR), .PCW(PCW), .PC_INC(PC_INC)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .stall_evt(stall_evt),
  .act_tid(act_tid), .issue_vld(issue_vld), .pc_bank(pc_bank)
);

// File: tb/tsw_ctrl_tb.sv
module tsw_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int PCW = 32;
  localparam int INC = 4;
  localparam int BASE = 32'h1000;
  localparam int STEP = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] thr_en = '1;
  logic stall_evt = 1'b0, ret_evt = 1'b0;
  logic [1:0] ret_tid = '0;
  logic [1:0] act_tid;
  logic issue_vld;
  logic [N*PCW-1:0] pc_bank;

  int checks = 0, errors = 0;

  bit        m_run;
  int        m_act;
  bit [N-1:0] m_rdy;
  bit [PCW-1:0] m_pc [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsw_ctrl u_dut (.clk(clk), .rst_n(rst_n), .thr_en(thr_en), .stall_evt(stall_evt),
    .ret_evt(ret_evt), .ret_tid(ret_tid), .act_tid(act_tid), .issue_vld(issue_vld),
    .pc_bank(pc_bank));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [N-1:0] en_eff();
    return thr_en | N'(1);
  endfunction

  task automatic model_reset();
    m_run = 1; m_act = 0; m_rdy = en_eff();
    for (int t = 0; t < N; t++) m_pc[t] = PCW'(BASE + t*STEP);
  endtask

  // expected state after the coming edge, from the requirements
  task automatic model_step();
    bit [N-1:0] nr;
    bit st;
    nr = m_rdy;
    st = m_run && stall_evt;
    if (m_run) m_pc[m_act] = m_pc[m_act] + PCW'(INC);
    if (st) nr[m_act] = 0;
    if (ret_evt && !(st && int'(ret_tid) == m_act)) nr[ret_tid] = 1;
    if (st) m_run = 0;
    else if (!m_run) begin
      for (int k = 1; k <= N; k++) begin
        int i;
        i = (m_act + k) % N;
        if (!m_run && m_rdy[i] && en_eff()[i]) begin m_run = 1; m_act = i; end
      end
    end
    m_rdy = nr;
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " issue_vld"}, 64'(issue_vld), 64'(m_run));
    chk({tag, " act_tid"}, 64'(act_tid), 64'(m_act));
    for (int t = 0; t < N; t++) chk({tag, " pc"}, 64'(pc_bank[t*PCW +: PCW]), 64'(m_pc[t]));
  endtask

  task automatic step(input logic st, input logic rv, input int rt, input string tag);
    stall_evt = st; ret_evt = rv; ret_tid = 2'(rt);
    model_step();
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic do_reset(input logic [N-1:0] en);
    rst_n = 0; thr_en = en; stall_evt = 0; ret_evt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    cmp_all("R1 reset");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset(4'b1011);
    chk("R1 act", 64'(act_tid), 0);
    chk("R1 vld", 64'(issue_vld), 1);
    chk("R1 pc2", 64'(pc_bank[2*PCW +: PCW]), 64'h3000);
    repeat (3) step(0, 0, 0, "R2");
    chk("R2 pc0", 64'(pc_bank[0 +: PCW]), 64'h100c);
    step(1, 0, 0, "R3");
    chk("R3 gap", 64'(issue_vld), 0);
    step(0, 0, 0, "R4");
    chk("R4 next", 64'(act_tid), 1);
    chk("R3 resume", 64'(issue_vld), 1);
    step(0, 0, 0, "R2");
    step(1, 0, 0, "R5");
    step(0, 0, 0, "R9");
    chk("R9 skip disabled", 64'(act_tid), 3);
    step(1, 1, 3, "R8");
    step(0, 0, 0, "R8");
    chk("R8 still stalled", 64'(issue_vld), 0);
    chk("R5 not reissued", 64'(act_tid), 3);
    step(1, 0, 0, "R10");
    chk("R10 ignored", 64'(issue_vld), 0);
    step(0, 1, 1, "R6");
    chk("R6 wait", 64'(issue_vld), 0);
    step(0, 0, 0, "R6");
    chk("R6 resume tid", 64'(act_tid), 1);
    chk("R6 resume pc", 64'(pc_bank[PCW +: PCW]), 64'h2008);
    step(0, 1, 1, "R7");
    step(0, 0, 0, "R7");
    chk("R7 still running", 64'(issue_vld), 1);

    do_reset(4'b1111);
    for (int c = 0; c < 6000; c++) begin
      if (c >= 3000 && c % 250 == 0) thr_en = 4'($urandom_range(0, 15));
      step(($urandom % 4) == 0, ($urandom % 3) == 0, int'($urandom % N),
           "R2 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule